// File: doc/BRIEF.md
# Processor Clock-Stop State Controller

This controller sequences a processor core through its operating contexts (normal, system-management and halted) and through a low-power clock-stop state. A stop-clock request puts it in the clock-stop state from any of the three contexts. It records which context it left and goes back to that context when the request drops. While the core is stopped, most of its clock tree is switched off. The controller itself runs on a free-running clock and keeps watching its inputs.

While halted or stopped, the controller accepts cache snoops from the system. It enters a short snoop sub-state and reports the hit indications supplied by the tag lookup outside the block. When the snooped line is modified, it requests a writeback and stays in the sub-state until the writeback is acknowledged. Otherwise it returns after a fixed dwell. An INIT request that arrives while stopped is held back and released as a one-cycle pulse once the stop request goes away. Everything except the snoop-accept decision and the snoop-exit decision is a registered output.

Top module: `clkstop_ctrl`

## Requirements
- R1: With `stop_req` high at a clock edge in normal (mode 0), SMM (mode 1) or halt (mode 2), and no snoop accepted at that edge, `mode` becomes 3 (clock-stop).
- R2: In mode 3, a low `stop_req` with no snoop accepted returns `mode` to the recorded context. The context is held in 2 bits: 00 normal, 01 SMM, 10 halt.
- R3: A snoop is accepted only when `addr_strobe` is high, at least one of `ahold`, `boff`, `hlda` is high, and `mode` is 2 or 3. `mode` then becomes 4. Acceptance takes priority over stop entry and stop release in the same cycle. A strobe that does not meet these conditions leaves `mode` unchanged.
- R4: In mode 3, or in mode 4 entered from mode 3, `init_req` sets `init_pending` and `init_fire` stays low. On the release edge `init_fire` pulses for one cycle and `init_pending` clears. In any other state `init_fire` follows `init_req` one cycle later.
- R5: `core_clk_en` is high exactly when `mode` is 0 or 1. `dbus_float` is high exactly when `mode` is 3.
- R6: After a snoop with `snoop_hitm` low, `mode` returns to the state the snoop left exactly DWELL (default 2) clock edges after the accepting edge.
- R7: A snoop with `snoop_hitm` high sets `hitm_out`. `wb_req` is high in any cycle of that snoop whose previous cycle had both `boff` and `hlda` low, so the writeback starts at once under `ahold` and waits while the bus is held off.
- R8: During a modified-hit snoop, `mode` stays 4 until `wb_done` is seen with `wb_req` high. At that edge `mode` returns and `hitm_out` and `wb_req` clear together.
- R9: `hit_out` shows the `snoop_hit` captured at acceptance for the whole snoop. `snoop_done` pulses for one cycle after each snoop exit.
- R10: `rst` is synchronous and active high. It forces mode 0 with `core_clk_en` high and clears `init_pending` and all snoop outputs. It wins over a stop release at the same edge.
- R11: In mode 0, `smm_entry` gives mode 1 and `halt_cmd` gives mode 2, with stop, then SMM entry, then halt in priority order. In mode 1, `smm_resume` gives mode 0. In mode 2, `wake_evt` gives mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-clock request |
| smm_entry | input | 1 | Enter system-management context |
| smm_resume | input | 1 | Leave system-management context |
| halt_cmd | input | 1 | Core executes a halt |
| wake_evt | input | 1 | Event that ends halt |
| init_req | input | 1 | INIT request |
| addr_strobe | input | 1 | External snoop address strobe |
| ahold | input | 1 | System holds the address bus |
| boff | input | 1 | Bus back-off in force |
| hlda | input | 1 | Bus hold acknowledged |
| snoop_hit | input | 1 | Tag lookup hit |
| snoop_hitm | input | 1 | Tag lookup hit on a modified line |
| wb_done | input | 1 | Writeback finished |
| mode | output | 3 | 0 normal, 1 SMM, 2 halt, 3 clock-stop, 4 snoop |
| core_clk_en | output | 1 | Core clock gate enable |
| dbus_float | output | 1 | Data bus and parity tri-state enable |
| init_pending | output | 1 | INIT held during clock-stop |
| init_fire | output | 1 | One-cycle INIT to the core |
| hit_out | output | 1 | Snoop hit indication |
| hitm_out | output | 1 | Snoop modified-hit indication |
| wb_req | output | 1 | Writeback request |
| snoop_done | output | 1 | Snoop finished pulse |

## Verification
Stop entry and release are tried from each of the three contexts. This separates a controller that records its origin from one that always returns to normal. Snoops are tried in several forms: with no hit, with a clean hit, with a modified hit under address-hold, and with a modified hit under back-off. Together they tell the fixed-dwell exit apart from the acknowledge-driven exit, and an immediate writeback apart from a deferred one. Strobes without bus ownership or outside halt and stop, a snoop colliding with a stop request, INIT during stop compared with INIT in normal, and reset colliding with a release cover the priority rules.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_SMM    = 3'd1,
    MD_HALT   = 3'd2,
    MD_STOP   = 3'd3,
    MD_INQ    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CX_NORMAL = 2'b00,
    CX_SMM    = 2'b01,
    CX_HALT   = 2'b10
  } ctx_e;

  function automatic mode_e ctx_to_mode(ctx_e c);
    case (c)
      CX_SMM:  return MD_SMM;
      CX_HALT: return MD_HALT;
      default: return MD_NORMAL;
    endcase
  endfunction
endpackage

// File: rtl/cs_mode_fsm.sv
module cs_mode_fsm
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stop_req,
  input  logic  smm_entry,
  input  logic  smm_resume,
  input  logic  halt_cmd,
  input  logic  wake_evt,
  input  logic  addr_strobe,
  input  logic  bus_owned,
  input  logic  inq_finish,
  output mode_e mode,
  output logic  snoop_go,
  output logic  stop_hold,
  output logic  stop_release,
  output logic  core_clk_en,
  output logic  dbus_float
);
  ctx_e  ctx_q, ctx_d;
  logic  back_to_stop_q, back_to_stop_d;
  mode_e mode_d;

  assign snoop_go     = addr_strobe && bus_owned && (mode == MD_HALT || mode == MD_STOP);
  assign stop_release = (mode == MD_STOP) && !stop_req && !snoop_go;
  assign stop_hold    = (mode == MD_STOP) || (mode == MD_INQ && back_to_stop_q);

  always_comb begin
    mode_d         = mode;
    ctx_d          = ctx_q;
    back_to_stop_d = back_to_stop_q;
    case (mode)
      MD_NORMAL: begin
        if (stop_req) begin
          mode_d = MD_STOP;
          ctx_d  = CX_NORMAL;
        end else if (smm_entry) begin
          mode_d = MD_SMM;
        end else if (halt_cmd) begin
          mode_d = MD_HALT;
        end
      end
      MD_SMM: begin
        if (stop_req) begin
          mode_d = MD_STOP;
          ctx_d  = CX_SMM;
        end else if (smm_resume) begin
          mode_d = MD_NORMAL;
        end
      end
      MD_HALT: begin
        if (snoop_go) begin
          mode_d         = MD_INQ;
          back_to_stop_d = 1'b0;
        end else if (stop_req) begin
          mode_d = MD_STOP;
          ctx_d  = CX_HALT;
        end else if (wake_evt) begin
          mode_d = MD_NORMAL;
        end
      end
      MD_STOP: begin
        if (snoop_go) begin
          mode_d         = MD_INQ;
          back_to_stop_d = 1'b1;
        end else if (!stop_req) begin
          mode_d = ctx_to_mode(ctx_q);
        end
      end
      MD_INQ: begin
        if (inq_finish) mode_d = back_to_stop_q ? MD_STOP : MD_HALT;
      end
      default: mode_d = MD_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode           <= MD_NORMAL;
      ctx_q          <= CX_NORMAL;
      back_to_stop_q <= 1'b0;
      core_clk_en    <= 1'b1;
      dbus_float     <= 1'b0;
    end else begin
      mode           <= mode_d;
      ctx_q          <= ctx_d;
      back_to_stop_q <= back_to_stop_d;
      core_clk_en    <= (mode_d == MD_NORMAL) || (mode_d == MD_SMM);
      dbus_float     <= (mode_d == MD_STOP);
    end
  end
endmodule

// File: rtl/cs_inquire.sv
module cs_inquire #(
  parameter int DWELL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic snoop_go,
  input  logic snoop_hit,
  input  logic snoop_hitm,
  input  logic bus_busy,
  input  logic wb_done,
  output logic inq_finish,
  output logic hit_out,
  output logic hitm_out,
  output logic wb_req,
  output logic snoop_done
);
  localparam int CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign inq_finish = busy_q &&
                      ((!hitm_out && cnt_q == LAST) || (hitm_out && wb_req && wb_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      hit_out    <= 1'b0;
      hitm_out   <= 1'b0;
      wb_req     <= 1'b0;
      snoop_done <= 1'b0;
    end else begin
      snoop_done <= inq_finish;
      if (snoop_go) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        hit_out  <= snoop_hit;
        hitm_out <= snoop_hitm;
        wb_req   <= snoop_hitm && !bus_busy;
      end else if (inq_finish) begin
        busy_q   <= 1'b0;
        hit_out  <= 1'b0;
        hitm_out <= 1'b0;
        wb_req   <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        if (hitm_out) wb_req <= !bus_busy;
      end
    end
  end
endmodule

// File: rtl/cs_init_defer.sv
module cs_init_defer (
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic stop_hold,
  input  logic stop_release,
  output logic init_pending,
  output logic init_fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      init_pending <= 1'b0;
      init_fire    <= 1'b0;
    end else if (stop_release) begin
      init_fire    <= init_pending || init_req;
      init_pending <= 1'b0;
    end else if (stop_hold) begin
      init_pending <= init_pending || init_req;
      init_fire    <= 1'b0;
    end else begin
      init_pending <= 1'b0;
      init_fire    <= init_req;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int DWELL = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       smm_entry,
  input  logic       smm_resume,
  input  logic       halt_cmd,
  input  logic       wake_evt,
  input  logic       init_req,
  input  logic       addr_strobe,
  input  logic       ahold,
  input  logic       boff,
  input  logic       hlda,
  input  logic       snoop_hit,
  input  logic       snoop_hitm,
  input  logic       wb_done,
  output logic [2:0] mode,
  output logic       core_clk_en,
  output logic       dbus_float,
  output logic       init_pending,
  output logic       init_fire,
  output logic       hit_out,
  output logic       hitm_out,
  output logic       wb_req,
  output logic       snoop_done
);
  mode_e mode_q;
  logic  snoop_go, stop_hold, stop_release, inq_finish;

  assign mode = mode_q;

  cs_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .stop_req     (stop_req),
    .smm_entry    (smm_entry),
    .smm_resume   (smm_resume),
    .halt_cmd     (halt_cmd),
    .wake_evt     (wake_evt),
    .addr_strobe  (addr_strobe),
    .bus_owned    (ahold || boff || hlda),
    .inq_finish   (inq_finish),
    .mode         (mode_q),
    .snoop_go     (snoop_go),
    .stop_hold    (stop_hold),
    .stop_release (stop_release),
    .core_clk_en  (core_clk_en),
    .dbus_float   (dbus_float)
  );

  cs_inquire #(.DWELL(DWELL)) u_inq (
    .clk        (clk),
    .rst        (rst),
    .snoop_go   (snoop_go),
    .snoop_hit  (snoop_hit),
    .snoop_hitm (snoop_hitm),
    .bus_busy   (boff || hlda),
    .wb_done    (wb_done),
    .inq_finish (inq_finish),
    .hit_out    (hit_out),
    .hitm_out   (hitm_out),
    .wb_req     (wb_req),
    .snoop_done (snoop_done)
  );

  cs_init_defer u_init (
    .clk          (clk),
    .rst          (rst),
    .init_req     (init_req),
    .stop_hold    (stop_hold),
    .stop_release (stop_release),
    .init_pending (init_pending),
    .init_fire    (init_fire)
  );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic [2:0] mode,
  input logic       core_clk_en,
  input logic       dbus_float,
  input logic       init_pending,
  input logic       init_fire,
  input logic       hitm_out,
  input logic       wb_req,
  input logic       snoop_done
);
  AST_STOP_ENTER: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd0 || mode == 3'd1) && stop_req) |=> mode == 3'd3); // R1
  AST_CLKEN_CTX: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (mode == 3'd0 || mode == 3'd1)); // R5
  AST_FLOAT_STOP: assert property (@(posedge clk) disable iff (rst)
    dbus_float |-> mode == 3'd3); // R5
  AST_INIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && $past(mode) == 3'd3) |-> !init_fire); // R4
  AST_WB_HITM: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> hitm_out); // R7
  AST_HITM_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(hitm_out) |-> mode != 3'd4); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    snoop_done |=> !snoop_done); // R9
  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (mode == 3'd0 && !init_pending && core_clk_en)); // R10
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .stop_req     (stop_req),
  .mode         (mode),
  .core_clk_en  (core_clk_en),
  .dbus_float   (dbus_float),
  .init_pending (init_pending),
  .init_fire    (init_fire),
  .hitm_out     (hitm_out),
  .wb_req       (wb_req),
  .snoop_done   (snoop_done)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, smm_entry = 0, smm_resume = 0, halt_cmd = 0, wake_evt = 0;
  logic init_req = 0, addr_strobe = 0, ahold = 0, boff = 0, hlda = 0;
  logic snoop_hit = 0, snoop_hitm = 0, wb_done = 0;
  logic [2:0] mode;
  logic core_clk_en, dbus_float, init_pending, init_fire;
  logic hit_out, hitm_out, wb_req, snoop_done;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  clkstop_ctrl i_clkstop_ctrl (.*);

  // behavioural reference
  int m_st = 0, m_ctx = 0, m_cnt = 0;
  bit m_rs, m_hf, m_hit, m_hitm, m_wb, m_done, m_pend, m_fire, m_clk = 1, m_flt;

  always @(posedge clk) begin
    int nst, nctx; bit go, fin, rel, hold, bsy, nrs;
    cycles++;
    if (rst) begin
      m_st = 0; m_ctx = 0; m_rs = 0; m_cnt = 0; m_hf = 0; m_hit = 0; m_hitm = 0;
      m_wb = 0; m_done = 0; m_pend = 0; m_fire = 0; m_clk = 1; m_flt = 0;
    end else begin
      go   = addr_strobe && (ahold || boff || hlda) && (m_st == 2 || m_st == 3);
      fin  = (m_st == 4) && ((!m_hf && m_cnt == 1) || (m_hf && m_wb && wb_done));
      rel  = (m_st == 3) && !stop_req && !go;
      hold = (m_st == 3) || (m_st == 4 && m_rs);
      bsy  = boff || hlda;
      nst = m_st; nctx = m_ctx; nrs = m_rs;
      if (m_st == 0) begin
        if (stop_req) begin nst = 3; nctx = 0; end
        else if (smm_entry) nst = 1;
        else if (halt_cmd) nst = 2;
      end else if (m_st == 1) begin
        if (stop_req) begin nst = 3; nctx = 1; end
        else if (smm_resume) nst = 0;
      end else if (m_st == 2) begin
        if (go) begin nst = 4; nrs = 0; end
        else if (stop_req) begin nst = 3; nctx = 2; end
        else if (wake_evt) nst = 0;
      end else if (m_st == 3) begin
        if (go) begin nst = 4; nrs = 1; end
        else if (!stop_req) nst = m_ctx;
      end else if (fin) nst = m_rs ? 3 : 2;
      m_done = fin;
      if (go) begin
        m_cnt = 0; m_hf = snoop_hitm; m_hit = snoop_hit; m_hitm = snoop_hitm;
        m_wb = snoop_hitm && !bsy;
      end else if (fin) begin
        m_hf = 0; m_hit = 0; m_hitm = 0; m_wb = 0;
      end else if (m_st == 4) begin
        if (m_cnt < 1) m_cnt++;
        if (m_hf) m_wb = !bsy;
      end
      if (rel) begin m_fire = m_pend || init_req; m_pend = 0; end
      else if (hold) begin m_pend = m_pend || init_req; m_fire = 0; end
      else begin m_pend = 0; m_fire = init_req; end
      m_st = nst; m_ctx = nctx; m_rs = nrs;
      m_clk = (nst == 0 || nst == 1); m_flt = (nst == 3);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (!done_flag) begin
    chk("R2",  "mode",         mode,         m_st);
    chk("R5",  "core_clk_en",  core_clk_en,  m_clk);
    chk("R5",  "dbus_float",   dbus_float,   m_flt);
    chk("R4",  "init_pending", init_pending, m_pend);
    chk("R4",  "init_fire",    init_fire,    m_fire);
    chk("R9",  "hit_out",      hit_out,      m_hit);
    chk("R7",  "hitm_out",     hitm_out,     m_hitm);
    chk("R7",  "wb_req",       wb_req,       m_wb);
    chk("R9",  "snoop_done",   snoop_done,   m_done);
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finish_run();
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic snoop(bit own_a, bit own_b, bit h, bit hm);
    addr_strobe = 1; ahold = own_a; boff = own_b; snoop_hit = h; snoop_hitm = hm;
    tick();
    addr_strobe = 0; snoop_hit = 0; snoop_hitm = 0;
  endtask

  initial begin
    tick(3);
    chk("R10", "mode after reset", mode, 0);
    chk("R10", "clk_en after reset", core_clk_en, 1);
    rst = 0;

    // R1/R2 from normal
    stop_req = 1; tick();
    chk("R1", "stop from normal", mode, 3);
    tick(2); stop_req = 0; tick();
    chk("R2", "back to normal", mode, 0);

    // R11 SMM, R1/R2 from SMM
    smm_entry = 1; tick(); smm_entry = 0;
    chk("R11", "enter smm", mode, 1);
    stop_req = 1; tick(2); stop_req = 0; tick();
    chk("R2", "back to smm", mode, 1);
    smm_resume = 1; tick(); smm_resume = 0;
    chk("R11", "leave smm", mode, 0);

    // halt, stop, release to halt
    halt_cmd = 1; tick(); halt_cmd = 0;
    chk("R11", "enter halt", mode, 2);
    stop_req = 1; tick();
    chk("R1", "stop from halt", mode, 3);
    stop_req = 0; tick();
    chk("R2", "back to halt", mode, 2);

    // R3/R6 clean snoop in halt
    snoop(1, 0, 0, 0);
    chk("R3", "snoop accepted in halt", mode, 4);
    tick();
    chk("R6", "still in snoop", mode, 4);
    tick();
    chk("R6", "dwell exit", mode, 2);
    chk("R9", "done pulse", snoop_done, 1);
    ahold = 0;

    // R3 ignored strobes
    addr_strobe = 1; tick(); addr_strobe = 0;
    chk("R3", "strobe without ownership", mode, 2);
    wake_evt = 1; tick(); wake_evt = 0;
    chk("R11", "wake from halt", mode, 0);
    ahold = 1; addr_strobe = 1; tick(); addr_strobe = 0; ahold = 0;
    chk("R3", "strobe in normal", mode, 0);

    // R4 INIT deferred
    stop_req = 1; tick();
    init_req = 1; tick(); init_req = 0;
    chk("R4", "init pending", init_pending, 1);
    tick();
    chk("R4", "no fire while stopped", init_fire, 0);
    stop_req = 0; tick();
    chk("R4", "fire on release", init_fire, 1);
    tick();
    chk("R4", "fire one cycle", init_fire, 0);

    // R7/R8 modified hit under ahold from stop
    stop_req = 1; tick();
    snoop(1, 0, 1, 1);
    chk("R7", "hitm set", hitm_out, 1);
    chk("R7", "wb immediate", wb_req, 1);
    chk("R9", "hit set", hit_out, 1);
    tick(2);
    chk("R8", "waits for writeback", mode, 4);
    wb_done = 1; tick(); wb_done = 0;
    chk("R8", "return to stop", mode, 3);
    chk("R8", "hitm cleared", hitm_out, 0);
    ahold = 0; stop_req = 0; tick();
    chk("R2", "release after snoop", mode, 0);

    // R7 deferred writeback under back-off, from halt
    halt_cmd = 1; tick(); halt_cmd = 0;
    boff = 1; snoop(0, 1, 0, 1);
    tick(2);
    chk("R7", "wb held by backoff", wb_req, 0);
    boff = 0; tick();
    chk("R7", "wb after backoff", wb_req, 1);
    wb_done = 1; tick(); wb_done = 0;
    chk("R8", "return to halt", mode, 2);

    // R3 priority: snoop beats stop entry
    stop_req = 1; snoop(1, 0, 0, 0); ahold = 0;
    chk("R3", "snoop priority", mode, 4);
    tick(2);
    chk("R3", "back to halt then stop", mode, 2);
    tick();
    chk("R1", "stop after snoop", mode, 3);

    // R10 reset wins over release
    init_req = 1; tick(); init_req = 0;
    stop_req = 0; rst = 1; tick(); rst = 0;
    chk("R10", "reset over release", mode, 0);
    chk("R10", "pending cleared", init_pending, 0);
    chk("R10", "no fire", init_fire, 0);

    // R4 INIT outside stop passes straight
    init_req = 1; tick(); init_req = 0;
    chk("R4", "init in normal", init_fire, 1);
    tick(3);
    finish_run();
  end
endmodule